// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management end of a 10/100 Ethernet transceiver. It listens to a two-wire serial management bus (a management clock plus one bidirectional data line, here split into input, output and output enable). It decodes read and write frames addressed to its own PHY address. It holds a small bank of registers for basic control, status, device identity and auto-negotiation. Read data goes back on the data line, and writes are applied to the writable registers.

The management clock has no fixed relation to the system clock. Both bus lines are therefore brought into the system clock domain through synchronisers before any frame is decoded. The PHY address is taken from strap pins while hardware reset is held. An isolate input cuts the block off from the bus entirely.

A write that sets the top control bit starts a soft reset. The control register reads back with that bit set for a fixed, parameterised number of system clocks and then returns to its default value. Any control write that arrives during that window is dropped.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After hardware reset the data line is not driven, and registers 0..6 read 0x3100 (control), 0x7849 (status), 0x0000, 0x8201 (identifier words), 0x01E1 (advertisement), 0x0080 (partner ability) and 0x0000 (expansion).
- R2: A frame is at least 32 ones, start bits 0 then 1, a 2-bit opcode (10 read, 01 write), a 5-bit PHY address and a 5-bit register address, all sent MSB first. The first turnaround bit of a matching read is undriven. The block drives 0 in the second turnaround bit, drives the 16 data bits MSB first, and releases the line after the last data bit.
- R3: A matching write frame (two turnaround bits, then 16 data bits MSB first) stores its data in register 4, or in register 0 when bit 15 of the data is 0. A later read returns the stored value.
- R4: Writing register 0 with bit 15 = 1 starts a soft reset. Register 0 reads 0xB100 while it runs. After RST_CYCLES system clocks it reads 0x3100, with bit 15 cleared without a second write.
- R5: While a soft reset runs, writes to register 0 leave it unchanged.
- R6: A write to register 0 with bit 15 = 0 starts no reset and simply stores the other bits.
- R7: A frame whose PHY address differs from the latched address changes no register and never drives the data line.
- R8: Register addresses 7..31 read 0x0000, and writes to them change nothing.
- R9: While isolate is high the data line is never driven and frames change no register.
- R10: The PHY address is sampled from the strap inputs during hardware reset. Later strap changes have no effect.
- R11: A frame preceded by fewer than 32 consecutive ones is ignored.
- R12: Status register bit 2 follows the link input and bit 5 follows the auto-negotiation-done input. The other status bits keep their default values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset; strap sampling happens while low |
| mdc | input | 1 | Management clock, asynchronous to clk |
| mdio_in | input | 1 | Level seen on the management data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line |
| phy_addr_strap | input | 5 | Strap pins giving the PHY address |
| isolate | input | 1 | High disconnects the block from the management bus |
| link_up | input | 1 | Link state shown in status bit 2 |
| an_done | input | 1 | Auto-negotiation complete, shown in status bit 5 |

## Verification
The bench targets the soft-reset window. It reads register 0 and writes it again while the reset counter is still running, then waits past the window. A design that clears bit 15 at once, never clears it, or accepts the mid-reset write shows up as a wrong read-back. A preamble of 31 ones is sent to catch a decoder that starts frames too early. Frames to a strap value changed after reset, frames to a foreign address and frames sent while isolated are checked both for register side effects and for any enable on the data line. This catches a decoder that drives the bus or writes when it should not. Turnaround timing is checked on every read, so an enable that comes a bit early or late, or a missing release after the data bits, is reported.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int unsigned WORD_W = 16;

   typedef enum logic [2:0] {
      ST_PRE,
      ST_HDR,
      ST_TA,
      ST_WDATA,
      ST_RDATA
   } mdio_state_e;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   localparam logic [4:0] RA_CTRL = 5'd0;
   localparam logic [4:0] RA_STAT = 5'd1;
   localparam logic [4:0] RA_ID1  = 5'd2;
   localparam logic [4:0] RA_ID2  = 5'd3;
   localparam logic [4:0] RA_ADV  = 5'd4;
   localparam logic [4:0] RA_LPA  = 5'd5;
   localparam logic [4:0] RA_EXP  = 5'd6;

   localparam logic [WORD_W-1:0] CTRL_DEF = 16'h3100;
   localparam logic [WORD_W-1:0] STAT_DEF = 16'h7849;
   localparam logic [WORD_W-1:0] ADV_DEF  = 16'h01E1;
   localparam logic [WORD_W-1:0] LPA_DEF  = 16'h0080;
   localparam logic [WORD_W-1:0] EXP_DEF  = 16'h0000;

   localparam int unsigned SRST_BIT   = 15;
   localparam int unsigned LINK_BIT   = 2;
   localparam int unsigned ANDONE_BIT = 5;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= INIT;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= INIT;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
   import mdio_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              isolate,
   input  logic              mdc_s,
   input  logic              mdio_s,
   input  logic [ADDR_W-1:0] phy_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              out_bit,
   output logic              out_en
);
   localparam int unsigned HDR_BITS = 3 + 2 * ADDR_W;
   localparam int unsigned PRE_CW   = $clog2(PRE_LEN + 1);
   localparam int unsigned MAX_CNT  = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
   localparam int unsigned CNT_W    = $clog2(MAX_CNT);
   localparam logic [PRE_CW-1:0] PRE_MAX  = PRE_CW'(PRE_LEN);
   localparam logic [CNT_W-1:0]  HDR_LAST = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0]  DAT_LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0]  ONE_CNT  = CNT_W'(1);

   mdio_state_e         state;
   logic [PRE_CW-1:0]   ones;
   logic [CNT_W-1:0]    cnt;
   logic [HDR_BITS-2:0] hdr_q;
   logic [HDR_BITS-1:0] hdr_nx;
   logic [DATA_W-1:0]   sh;
   logic                is_rd;
   logic                mdc_d;
   logic                rise, fall;
   logic                start_ok;
   logic [1:0]          op_f;
   logic [ADDR_W-1:0]   phy_f;
   logic                hit;

   assign rise     = mdc_s & ~mdc_d;
   assign fall     = ~mdc_s & mdc_d;
   assign hdr_nx   = {hdr_q, mdio_s};
   assign start_ok = hdr_nx[HDR_BITS-1];
   assign op_f     = hdr_nx[HDR_BITS-2 -: 2];
   assign phy_f    = hdr_nx[2*ADDR_W-1 -: ADDR_W];
   assign rd_addr  = hdr_nx[ADDR_W-1:0];
   assign hit      = start_ok && (op_f == OP_RD || op_f == OP_WR) && (phy_f == phy_addr);
   assign wr_data  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_PRE;
         ones    <= '0;
         cnt     <= '0;
         hdr_q   <= '0;
         sh      <= '0;
         is_rd   <= 1'b0;
         mdc_d   <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         out_bit <= 1'b1;
         out_en  <= 1'b0;
      end else begin
         mdc_d <= mdc_s;
         wr_en <= 1'b0;
         if (isolate) begin
            state  <= ST_PRE;
            ones   <= '0;
            cnt    <= '0;
            out_en <= 1'b0;
         end else begin
            case (state)
               ST_PRE: begin
                  if (fall) out_en <= 1'b0;
                  if (rise) begin
                     if (mdio_s) begin
                        if (ones != PRE_MAX) ones <= ones + 1'b1;
                     end else begin
                        if (ones == PRE_MAX) begin
                           state <= ST_HDR;
                           cnt   <= '0;
                        end
                        ones <= '0;
                     end
                  end
               end
               ST_HDR: begin
                  if (rise) begin
                     hdr_q <= hdr_nx[HDR_BITS-2:0];
                     cnt   <= cnt + 1'b1;
                     if (cnt == HDR_LAST) begin
                        cnt <= '0;
                        if (hit) begin
                           state   <= ST_TA;
                           is_rd   <= (op_f == OP_RD);
                           sh      <= rd_data;
                           wr_addr <= rd_addr;
                        end else begin
                           state <= ST_PRE;
                        end
                     end
                  end
               end
               ST_TA: begin
                  if (fall && is_rd && cnt == ONE_CNT) begin
                     out_en  <= 1'b1;
                     out_bit <= 1'b0;
                  end
                  if (rise) begin
                     if (cnt == ONE_CNT) begin
                        cnt   <= '0;
                        state <= is_rd ? ST_RDATA : ST_WDATA;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_RDATA: begin
                  if (fall) begin
                     out_bit <= sh[DATA_W-1];
                     sh      <= {sh[DATA_W-2:0], 1'b0};
                  end
                  if (rise) begin
                     if (cnt == DAT_LAST) begin
                        state <= ST_PRE;
                        cnt   <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_WDATA: begin
                  if (rise) begin
                     sh <= {sh[DATA_W-2:0], mdio_s};
                     if (cnt == DAT_LAST) begin
                        wr_en <= 1'b1;
                        state <= ST_PRE;
                        cnt   <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: state <= ST_PRE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned RST_CYCLES = 50,
   parameter logic [DATA_W-1:0] ID1_VAL = 16'h0000,
   parameter logic [DATA_W-1:0] ID2_VAL = 16'h8201
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              link_up,
   input  logic              an_done,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              rst_busy
);
   localparam int unsigned RC_W = $clog2(RST_CYCLES + 1);
   localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);
   localparam logic [RC_W-1:0] RC_END  = RC_W'(1);
   localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;

   logic [DATA_W-1:0] adv_q;
   logic [RC_W-1:0]   rcnt;
   logic [DATA_W-1:0] stat_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_DEF;
         adv_q    <= ADV_DEF;
         rst_busy <= 1'b0;
         rcnt     <= '0;
      end else begin
         if (rst_busy) begin
            if (rcnt == RC_END) begin
               rst_busy <= 1'b0;
               rcnt     <= '0;
               ctrl_q   <= CTRL_DEF;
            end else begin
               rcnt <= rcnt - 1'b1;
            end
         end else if (wr_en && wr_addr == ADDR_W'(RA_CTRL)) begin
            if (wr_data[SRST_BIT]) begin
               rst_busy <= 1'b1;
               rcnt     <= RC_LOAD;
               ctrl_q   <= CTRL_DEF | SRST_MASK;
            end else begin
               ctrl_q <= wr_data;
            end
         end
         if (wr_en && wr_addr == ADDR_W'(RA_ADV)) adv_q <= wr_data;
      end
   end

   always_comb begin
      stat_v             = STAT_DEF;
      stat_v[LINK_BIT]   = link_up;
      stat_v[ANDONE_BIT] = an_done;
   end

   always_comb begin
      case (rd_addr)
         ADDR_W'(RA_CTRL): rd_data = ctrl_q;
         ADDR_W'(RA_STAT): rd_data = stat_v;
         ADDR_W'(RA_ID1):  rd_data = ID1_VAL;
         ADDR_W'(RA_ID2):  rd_data = ID2_VAL;
         ADDR_W'(RA_ADV):  rd_data = adv_q;
         ADDR_W'(RA_LPA):  rd_data = LPA_DEF;
         ADDR_W'(RA_EXP):  rd_data = EXP_DEF;
         default:          rd_data = '0;
      endcase
   end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
   import mdio_pkg::*;
#(
   parameter int unsigned RST_CYCLES  = 50,
   parameter int unsigned PRE_LEN     = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 16,
   parameter logic [15:0] ID1_VAL     = 16'h0000,
   parameter logic [15:0] ID2_VAL     = 16'h8201
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc,
   input  logic              mdio_in,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic [ADDR_W-1:0] phy_addr_strap,
   input  logic              isolate,
   input  logic              link_up,
   input  logic              an_done
);
   if (DATA_W != WORD_W) begin : g_bad_data_w
      $error("DATA_W must equal the 16-bit register word");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("ADDR_W must cover the implemented register addresses");
   end
   if (RST_CYCLES < 2) begin : g_bad_rst
      $error("RST_CYCLES must be at least 2");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [ADDR_W-1:0] phy_q;
   logic              mdc_s, mdio_s;
   logic              link_s, an_s;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              out_en;
   logic [DATA_W-1:0] ctrl_q;
   logic              rst_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phy_q <= phy_addr_strap;
      else        phy_q <= phy_q;
   end

   mdio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b01)) u_bus_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({mdc, mdio_in}),
      .q   ({mdc_s, mdio_s})
   );

   mdio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b00)) u_stat_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({link_up, an_done}),
      .q   ({link_s, an_s})
   );

   mdio_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .isolate  (isolate),
      .mdc_s    (mdc_s),
      .mdio_s   (mdio_s),
      .phy_addr (phy_q),
      .rd_data  (rd_data),
      .rd_addr  (rd_addr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .out_bit  (mdio_out),
      .out_en   (out_en)
   );

   mdio_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES),
      .ID1_VAL(ID1_VAL), .ID2_VAL(ID2_VAL)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .link_up  (link_s),
      .an_done  (an_s),
      .ctrl_q   (ctrl_q),
      .rst_busy (rst_busy)
   );

   assign mdio_oe = out_en & ~isolate;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
   parameter int unsigned RST_CYCLES = 50
) (
   input logic        clk,
   input logic        rst_n,
   input logic        isolate,
   input logic        mdio_oe,
   input logic        mdio_out,
   input logic        rst_busy,
   input logic [15:0] ctrl_q,
   input logic        wr_en
);
   localparam int unsigned BL_W = $clog2(RST_CYCLES + 2);
   localparam logic [BL_W-1:0] BL_MAX = BL_W'(RST_CYCLES);

   logic [BL_W-1:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_len <= '0;
      else if (!rst_busy) busy_len <= '0;
      else if (busy_len != BL_MAX) busy_len <= busy_len + 1'b1;
   end

   // R2: the enable comes up in the second turnaround bit with a 0 on the line
   p_turnaround_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_out);

   // R3: a decoded write is a single-cycle strobe
   p_write_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R4: the soft reset window never outlasts RST_CYCLES clocks
   p_busy_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_busy |-> (busy_len < BL_MAX));

   // R5: control register frozen while the soft reset runs
   p_busy_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_busy && $past(rst_busy)) |-> $stable(ctrl_q));

   // R9: no write strobe leaves the decoder once isolate is seen
   p_isolate_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      isolate |=> !wr_en);
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .isolate  (isolate),
   .mdio_oe  (mdio_oe),
   .mdio_out (mdio_out),
   .rst_busy (rst_busy),
   .ctrl_q   (ctrl_q),
   .wr_en    (wr_en)
);

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int RST_CYC    = 4000;
   localparam int WD_LIMIT   = 150000;
   localparam logic [4:0] MY_PA    = 5'h0B;
   localparam logic [4:0] OTHER_PA = 5'h03;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mdc = 1'b0;
   logic       drv = 1'b1;
   logic [4:0] strap = MY_PA;
   logic       isolate = 1'b0;
   logic       link_up = 1'b0;
   logic       an_done = 1'b0;
   logic       mdio_out, mdio_oe;
   wire        mdio_line = mdio_oe ? mdio_out : drv;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int oe_cnt = 0;
   logic [15:0] m_ctrl = 16'h3100;
   logic [15:0] m_adv  = 16'h01E1;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_slave #(.RST_CYCLES(RST_CYC)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .mdc            (mdc),
      .mdio_in        (mdio_line),
      .mdio_out       (mdio_out),
      .mdio_oe        (mdio_oe),
      .phy_addr_strap (strap),
      .isolate        (isolate),
      .link_up        (link_up),
      .an_done        (an_done)
   );

   always @(negedge clk) if (mdio_oe) oe_cnt++;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input logic [4:0] ra);
      logic [15:0] s;
      s = 16'h7849;
      s[2] = link_up;
      s[5] = an_done;
      case (ra)
         5'd0: return m_ctrl;
         5'd1: return s;
         5'd3: return 16'h8201;
         5'd4: return m_adv;
         5'd5: return 16'h0080;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic mdc_bit(input logic b, output logic lv, output logic ov);
      @(negedge clk);
      mdc = 1'b0;
      drv = b;
      repeat (HALF-1) @(negedge clk);
      lv = mdio_line;
      ov = mdio_oe;
      @(negedge clk);
      mdc = 1'b1;
      repeat (HALF-1) @(negedge clk);
   endtask

   task automatic do_frame(input int pre_n, input logic lead0, input logic [1:0] op,
                           input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                           output logic [15:0] rd, output logic ta_ok);
      logic lv, ov;
      logic [13:0] hdr;
      rd = '0;
      ta_ok = 1'b1;
      hdr = {2'b01, op, pa, ra};
      if (lead0) mdc_bit(1'b0, lv, ov);
      for (int i = 0; i < pre_n; i++) mdc_bit(1'b1, lv, ov);
      for (int i = 13; i >= 0; i--) mdc_bit(hdr[i], lv, ov);
      if (op == 2'b10) begin
         mdc_bit(1'b1, lv, ov);
         if (ov) ta_ok = 1'b0;
         mdc_bit(1'b1, lv, ov);
         if (!ov || lv) ta_ok = 1'b0;
         for (int i = 15; i >= 0; i--) begin
            mdc_bit(1'b1, lv, ov);
            rd[i] = lv;
            if (!ov) ta_ok = 1'b0;
         end
         mdc_bit(1'b1, lv, ov);
         if (ov) ta_ok = 1'b0;
      end else begin
         mdc_bit(1'b1, lv, ov);
         mdc_bit(1'b0, lv, ov);
         for (int i = 15; i >= 0; i--) mdc_bit(wd[i], lv, ov);
         mdc_bit(1'b1, lv, ov);
      end
   endtask

   task automatic wr_reg(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
      logic [15:0] d;
      logic t;
      do_frame(32, 1'b0, 2'b01, pa, ra, wd, d, t);
   endtask

   task automatic rd_reg(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] d, output logic t);
      do_frame(32, 1'b0, 2'b10, pa, ra, 16'h0, d, t);
   endtask

   initial begin
      logic [15:0] d;
      logic t;
      int oe0;
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      strap = OTHER_PA;                      // R10: strap moves after reset
      check("R1 idle oe", {15'd0, mdio_oe}, 16'h0000);

      // R1 defaults and R2 read framing
      for (int r = 0; r < 7; r++) begin
         rd_reg(MY_PA, 5'(r), d, t);
         check("R1 default", d, exp_read(5'(r)));
         check("R2 turnaround", {15'd0, t}, 16'h0001);
      end

      // R12 status inputs
      link_up = 1'b1; an_done = 1'b1;
      repeat (10) @(negedge clk);
      rd_reg(MY_PA, 5'd1, d, t);
      check("R12 status", d, 16'h786D);

      // R3 writes to advertisement, R6 control write without reset
      wr_reg(MY_PA, 5'd4, 16'h05E1); m_adv = 16'h05E1;
      rd_reg(MY_PA, 5'd4, d, t);
      check("R3 adv write", d, 16'h05E1);
      wr_reg(MY_PA, 5'd0, 16'h0140); m_ctrl = 16'h0140;
      rd_reg(MY_PA, 5'd0, d, t);
      check("R6 ctrl store", d, 16'h0140);

      // R7 / R10 foreign address, including the post-reset strap value
      oe0 = oe_cnt;
      wr_reg(OTHER_PA, 5'd4, 16'hBEEF);
      rd_reg(OTHER_PA, 5'd4, d, t);
      check("R7 no drive", 16'(oe_cnt - oe0), 16'h0000);
      rd_reg(MY_PA, 5'd4, d, t);
      check("R10 strap latched", d, m_adv);

      // R8 unimplemented address
      wr_reg(MY_PA, 5'd26, 16'hFFFF);
      rd_reg(MY_PA, 5'd26, d, t);
      check("R8 unimpl read", d, 16'h0000);
      rd_reg(MY_PA, 5'd4, d, t);
      check("R8 no side effect", d, m_adv);

      // R11 short preamble
      do_frame(31, 1'b1, 2'b01, MY_PA, 5'd4, 16'h1234, d, t);
      rd_reg(MY_PA, 5'd4, d, t);
      check("R11 short preamble", d, m_adv);

      // R9 isolate
      isolate = 1'b1;
      oe0 = oe_cnt;
      rd_reg(MY_PA, 5'd4, d, t);
      wr_reg(MY_PA, 5'd4, 16'hABCD);
      check("R9 no drive", 16'(oe_cnt - oe0), 16'h0000);
      isolate = 1'b0;
      rd_reg(MY_PA, 5'd4, d, t);
      check("R9 write ignored", d, m_adv);

      // R4 / R5 soft reset window
      wr_reg(MY_PA, 5'd0, 16'h8000);
      rd_reg(MY_PA, 5'd0, d, t);
      check("R4 busy readback", d, 16'hB100);
      wr_reg(MY_PA, 5'd0, 16'h0100);
      rd_reg(MY_PA, 5'd0, d, t);
      check("R5 write during reset", d, 16'hB100);
      repeat (RST_CYC) @(negedge clk);
      m_ctrl = 16'h3100;
      rd_reg(MY_PA, 5'd0, d, t);
      check("R4 self clear", d, 16'h3100);

      // random traffic, R3/R8 against the model
      for (int k = 0; k < 24; k++) begin
         logic [4:0]  ra;
         logic [15:0] wd;
         ra = 5'($urandom % 9);
         if (ra == 5'd8) ra = 5'd17;
         wd = 16'($urandom);
         if ($urandom % 2) begin
            if (ra == 5'd0) wd[15] = 1'b0;
            do_frame(32 + int'($urandom % 4), 1'b0, 2'b01, MY_PA, ra, wd, d, t);
            if (ra == 5'd0) m_ctrl = wd;
            if (ra == 5'd4) m_adv = wd;
         end else begin
            rd_reg(MY_PA, ra, d, t);
            check("R3 random read", d, exp_read(ra));
            check("R2 random turnaround", {15'd0, t}, 16'h0001);
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule